// File: doc/BRIEF.md
# I2C Target Clock-Stretch Controller

This block decides, for an I2C target, when SCL must be held low and when it may be let go. A bit shifter elsewhere reports every falling SCL edge inside a byte as a one-cycle strobe with its bit position (1 to 9). The block combines that position with the buffer flags, the remaining-byte count, the address-compare result and the three stretch enables. From these it raises a stretch flag that software can read, and a hold-low request for the pad logic.

Each stretch is tied to one edge and one cause. Receive-side causes fire on edge 7. Transmit, address, write-data and 10-bit-address causes fire on edge 8. The acknowledge cause fires on edge 9. The block records the cause that raised the flag. A software clear is accepted only after the buffer access that cause demands, and only if the condition has gone away; otherwise the stretch is armed again.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset the stretch flag and the hold request are both 0.
- R2: With target mode on and the receive buffer full, a falling-edge strobe with bit position 7 sets the flag on the next clock. A clear with no receive-buffer read since the set is ignored. After a read, a clear with the buffer no longer full releases the flag.
- R3: With target mode on, the transmit buffer empty and the byte-count-zero input low, a strobe at position 8 sets the flag. A clear is ignored until the transmit buffer has been written. With byte-count-zero high, no flag is set.
- R4: A strobe at position 8 sets the flag when the address-stretch enable is on, the current byte is an address byte and the address matched. A clear alone then releases it. An address byte that did not match sets nothing.
- R5: A strobe at position 8 sets the flag on a data byte (address-byte input low) received by the target (receive-direction input high) while the write-data stretch enable is on. A clear alone releases it. An address byte does not trigger this cause.
- R6: A strobe at position 9 with the acknowledge stretch enable on sets the flag, and a clear alone releases it. Position 8 does not trigger this cause.
- R7: During the low byte of a 10-bit address (ten-bit-low input high), a strobe at position 8 with the receive buffer still full sets the flag. Release needs a receive-buffer read followed by a clear.
- R8: The hold request equals the stretch flag while the module is enabled, and is 0 while it is disabled.
- R9: If a clear is accepted while the cause is still present (for example, the receive buffer is full again after a read), the flag stays set, and a further matching buffer access is required before the next clear.
- R10: With the module disabled, the flag is 0 from the next clock, and strobes set nothing.
- R11: A set event in a cycle where the flag is 0 wins over a clear in the same cycle. A matching buffer access and a clear in the same cycle release the flag.
- R12: No flag is set while target mode is off, or in a cycle without a falling-edge strobe.
- R13: When several causes meet on edge 8, the order of precedence is ten-bit address, then transmit-empty, then address, then write-data. A clear alone does not release a transmit-empty stretch that came in together with an address stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module enable |
| target_mode | input | 1 | Target operation is active |
| fall_stb | input | 1 | One-cycle strobe per SCL falling edge |
| bit_idx | input | 4 | Position of that edge within the byte, 1 to 9 |
| rx_full | input | 1 | Receive buffer holds unread data |
| tx_empty | input | 1 | Transmit buffer is empty |
| cnt_zero | input | 1 | Remaining byte count is zero |
| addr_byte | input | 1 | Current byte is an address byte |
| addr_match | input | 1 | Address comparator reports a match |
| tenbit_lo | input | 1 | Current byte is the low byte of a 10-bit address |
| rx_dir | input | 1 | Current byte is being received by the target |
| ie_addr | input | 1 | Address-stretch enable |
| ie_wdata | input | 1 | Write-data stretch enable |
| ie_ack | input | 1 | Acknowledge-time stretch enable |
| host_rd_rx | input | 1 | Host read of the receive buffer (strobe) |
| host_wr_tx | input | 1 | Host write of the transmit buffer (strobe) |
| host_clr | input | 1 | Host clear of the stretch flag (strobe) |
| stretch | output | 1 | Stretch flag |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
Two pairs of functions can fall in the same cycle. The first is a set event arriving with a software clear while the flag is 0. The second is a clear arriving with the buffer access that the latched cause needs. The bench provokes both by pulsing the clear strobe in the same cycle as the position-9 strobe, and by pulsing the read strobe together with the clear while the receive buffer still reads full. In the first case the flag must be 1 after the edge. In the second the access counts as done and the buffer is taken as drained, so the flag must be 0 after the edge.

// File: rtl/scl_hold_pkg.sv
// Shared types for the target clock-stretch controller.
package scl_hold_pkg;

    // Reason the stretch flag was raised; decides what releases it.
    typedef enum logic [2:0] {
        CS_NONE     = 3'd0,
        CS_RX_FULL  = 3'd1,
        CS_TX_EMPTY = 3'd2,
        CS_TEN_HI   = 3'd3,
        CS_ADDR     = 3'd4,
        CS_WDATA    = 3'd5,
        CS_ACK      = 3'd6
    } cause_e;

endpackage

// File: rtl/stretch_event_detect.sv
// Decodes one falling-edge strobe into at most one stretch cause.
// Assumes bit_idx is valid whenever fall_stb is high. When several
// causes meet on one edge, the lowest candidate index wins
// (ten-bit, receive, transmit, address, write-data, acknowledge).
module stretch_event_detect
    import scl_hold_pkg::*;
#(
    parameter int BIT_W    = 4,
    parameter int RX_EDGE  = 7,
    parameter int TX_EDGE  = 8,
    parameter int ACK_EDGE = 9
) (
    input  logic             fall_stb,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             target_mode,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             cnt_zero,
    input  logic             addr_byte,
    input  logic             addr_match,
    input  logic             tenbit_lo,
    input  logic             rx_dir,
    input  logic             ie_addr,
    input  logic             ie_wdata,
    input  logic             ie_ack,
    output logic             evt_valid,
    output cause_e           evt_cause
);

    localparam int               N_SRC    = 6;
    localparam logic [BIT_W-1:0] RX_CODE  = RX_EDGE[BIT_W-1:0];
    localparam logic [BIT_W-1:0] TX_CODE  = TX_EDGE[BIT_W-1:0];
    localparam logic [BIT_W-1:0] ACK_CODE = ACK_EDGE[BIT_W-1:0];

    logic             at_rx, at_tx, at_ack;
    logic [N_SRC-1:0] hit;

    // Maps a candidate slot to its cause code.
    function automatic cause_e slot_cause(input int idx);
        case (idx)
            0:       slot_cause = CS_TEN_HI;
            1:       slot_cause = CS_RX_FULL;
            2:       slot_cause = CS_TX_EMPTY;
            3:       slot_cause = CS_ADDR;
            4:       slot_cause = CS_WDATA;
            default: slot_cause = CS_ACK;
        endcase
    endfunction

    // Qualifies the strobe by edge position and target mode.
    always_comb begin
        at_rx  = fall_stb && target_mode && (bit_idx == RX_CODE);
        at_tx  = fall_stb && target_mode && (bit_idx == TX_CODE);
        at_ack = fall_stb && target_mode && (bit_idx == ACK_CODE);
    end

    // Evaluates each candidate cause in precedence order.
    always_comb begin
        hit[0] = at_tx  && tenbit_lo && rx_full;
        hit[1] = at_rx  && rx_full;
        hit[2] = at_tx  && tx_empty && !cnt_zero;
        hit[3] = at_tx  && addr_byte && addr_match && ie_addr;
        hit[4] = at_tx  && !addr_byte && rx_dir && ie_wdata;
        hit[5] = at_ack && ie_ack;
    end

    // Picks the highest-precedence hit.
    always_comb begin
        evt_cause = CS_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (hit[i]) evt_cause = slot_cause(i);
        end
        evt_valid = |hit;
    end

endmodule

// File: rtl/stretch_flag_reg.sv
// Holds the stretch flag, the cause that raised it and whether the
// buffer access that cause needs has been seen. A clear is accepted
// only once that access is done. If the cause is still present at
// that moment, the flag stays set and a new access is needed.
// Assumes the host strobes last one cycle each.
module stretch_flag_reg
    import scl_hold_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   evt_valid,
    input  cause_e evt_cause,
    input  logic   rx_full,
    input  logic   tx_empty,
    input  logic   cnt_zero,
    input  logic   host_rd_rx,
    input  logic   host_wr_tx,
    input  logic   host_clr,
    output logic   flag
);

    logic   flag_q;
    cause_e cause_q;
    logic   acc_q;
    logic   need_acc, acc_stb, acc_now, cond_still;

    // Works out which access the latched cause needs and whether it persists.
    always_comb begin
        need_acc   = 1'b0;
        acc_stb    = 1'b0;
        cond_still = 1'b0;
        case (cause_q)
            CS_RX_FULL, CS_TEN_HI: begin
                need_acc   = 1'b1;
                acc_stb    = host_rd_rx;
                cond_still = rx_full && !host_rd_rx;
            end
            CS_TX_EMPTY: begin
                need_acc   = 1'b1;
                acc_stb    = host_wr_tx;
                cond_still = tx_empty && !cnt_zero && !host_wr_tx;
            end
            default: ;
        endcase
        acc_now = !need_acc || acc_q || acc_stb;
    end

    // Sets, re-arms or releases the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            flag_q  <= 1'b0;
            cause_q <= CS_NONE;
            acc_q   <= 1'b0;
        end else if (!flag_q) begin
            if (evt_valid) begin
                flag_q  <= 1'b1;
                cause_q <= evt_cause;
                acc_q   <= 1'b0;
            end
        end else if (host_clr && acc_now) begin
            if (cond_still) begin
                acc_q <= 1'b0;
            end else begin
                flag_q  <= 1'b0;
                cause_q <= CS_NONE;
                acc_q   <= 1'b0;
            end
        end else if (acc_stb) begin
            acc_q <= 1'b1;
        end
    end

    assign flag = flag_q;

    p_set_needs_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(evt_valid && enable));

    p_release_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(host_clr || !enable));

    p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !flag_q);

    p_read_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && flag_q && cause_q == CS_RX_FULL && !acc_q && !host_rd_rx) |=> flag_q);

    p_write_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && flag_q && cause_q == CS_TX_EMPTY && !acc_q && !host_wr_tx) |=> flag_q);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !flag_q && evt_valid) |=> flag_q);

    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && flag_q && cause_q == CS_RX_FULL && rx_full && !host_rd_rx) |=> flag_q);

    p_cause_kept_r13: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> cause_q != CS_NONE);

endmodule

// File: rtl/i2c_tgt_stretch.sv
// Top of the I2C target clock-stretch controller. It joins the edge
// decoder and the flag register, and masks the hold request with the
// module enable so that SCL is let go at once when the module is off.
module i2c_tgt_stretch
    import scl_hold_pkg::*;
#(
    parameter int BIT_W    = 4,
    parameter int RX_EDGE  = 7,
    parameter int TX_EDGE  = 8,
    parameter int ACK_EDGE = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             target_mode,
    input  logic             fall_stb,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             rx_full,
    input  logic             tx_empty,
    input  logic             cnt_zero,
    input  logic             addr_byte,
    input  logic             addr_match,
    input  logic             tenbit_lo,
    input  logic             rx_dir,
    input  logic             ie_addr,
    input  logic             ie_wdata,
    input  logic             ie_ack,
    input  logic             host_rd_rx,
    input  logic             host_wr_tx,
    input  logic             host_clr,
    output logic             stretch,
    output logic             scl_hold
);

    logic   evt_valid;
    cause_e evt_cause;
    logic   flag;

    stretch_event_detect #(
        .BIT_W   (BIT_W),
        .RX_EDGE (RX_EDGE),
        .TX_EDGE (TX_EDGE),
        .ACK_EDGE(ACK_EDGE)
    ) u_detect (
        .fall_stb   (fall_stb),
        .bit_idx    (bit_idx),
        .target_mode(target_mode),
        .rx_full    (rx_full),
        .tx_empty   (tx_empty),
        .cnt_zero   (cnt_zero),
        .addr_byte  (addr_byte),
        .addr_match (addr_match),
        .tenbit_lo  (tenbit_lo),
        .rx_dir     (rx_dir),
        .ie_addr    (ie_addr),
        .ie_wdata   (ie_wdata),
        .ie_ack     (ie_ack),
        .evt_valid  (evt_valid),
        .evt_cause  (evt_cause)
    );

    stretch_flag_reg u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .evt_valid (evt_valid),
        .evt_cause (evt_cause),
        .rx_full   (rx_full),
        .tx_empty  (tx_empty),
        .cnt_zero  (cnt_zero),
        .host_rd_rx(host_rd_rx),
        .host_wr_tx(host_wr_tx),
        .host_clr  (host_clr),
        .flag      (flag)
    );

    // Drives the readable flag and the enable-masked hold request.
    always_comb begin
        stretch  = flag;
        scl_hold = flag && enable;
    end

    p_hold_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> (stretch && enable));

    p_no_hold_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !scl_hold);

endmodule

// File: tb/tb_i2c_tgt_stretch.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected flag for each cycle
// it drives; the monitor pops it after the edge and compares.
module tb_i2c_tgt_stretch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1, target_mode = 1'b1;
    logic       fall_stb = 1'b0;
    logic [3:0] bit_idx = 4'd0;
    logic       rx_full = 0, tx_empty = 0, cnt_zero = 0;
    logic       addr_byte = 0, addr_match = 0, tenbit_lo = 0, rx_dir = 0;
    logic       ie_addr = 0, ie_wdata = 0, ie_ack = 0;
    logic       host_rd_rx = 0, host_wr_tx = 0, host_clr = 0;
    logic       stretch, scl_hold;

    typedef struct {
        logic  flag;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 0;

    always #10 clk = ~clk;

    i2c_tgt_stretch dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .target_mode(target_mode),
        .fall_stb(fall_stb), .bit_idx(bit_idx), .rx_full(rx_full),
        .tx_empty(tx_empty), .cnt_zero(cnt_zero), .addr_byte(addr_byte),
        .addr_match(addr_match), .tenbit_lo(tenbit_lo), .rx_dir(rx_dir),
        .ie_addr(ie_addr), .ie_wdata(ie_wdata), .ie_ack(ie_ack),
        .host_rd_rx(host_rd_rx), .host_wr_tx(host_wr_tx), .host_clr(host_clr),
        .stretch(stretch), .scl_hold(scl_hold)
    );

    // Drives one cycle of strobes and queues the flag expected after it.
    task automatic step(input logic fs, input logic [3:0] bi, input logic rd,
                        input logic wr, input logic clr, input logic exp,
                        input string tag);
        exp_t e;
        @(negedge clk);
        fall_stb = fs; bit_idx = bi;
        host_rd_rx = rd; host_wr_tx = wr; host_clr = clr;
        e.flag = exp; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        #1;
        fall_stb = 0; host_rd_rx = 0; host_wr_tx = 0; host_clr = 0;
    endtask

    // Monitor: compares the flag and the hold request (R8) after each edge.
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            logic hexp;
            e = q.pop_front();
            hexp = e.flag && enable;
            n_vec++;
            if (stretch !== e.flag) begin
                n_bad++;
                $display("FAIL %s stretch actual=%b expected=%b", e.tag, stretch, e.flag);
            end
            if (scl_hold !== hexp) begin
                n_bad++;
                $display("FAIL %s/R8 scl_hold actual=%b expected=%b", e.tag, scl_hold, hexp);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, "R1");

        // R2: receive-full stretch on edge 7
        rx_full = 1;
        step(1, 7, 0, 0, 0, 1, "R2");
        step(0, 0, 0, 0, 1, 1, "R2");
        step(0, 0, 1, 0, 0, 1, "R2");
        rx_full = 0;
        step(0, 0, 0, 0, 1, 0, "R2");

        // R3: transmit-empty stretch on edge 8
        tx_empty = 1;
        step(1, 8, 0, 0, 0, 1, "R3");
        step(0, 0, 0, 0, 1, 1, "R3");
        step(0, 0, 0, 1, 0, 1, "R3");
        tx_empty = 0;
        step(0, 0, 0, 0, 1, 0, "R3");
        tx_empty = 1; cnt_zero = 1;
        step(1, 8, 0, 0, 0, 0, "R3");
        tx_empty = 0; cnt_zero = 0;

        // R12: gating by target mode and strobe
        rx_full = 1; target_mode = 0;
        step(1, 7, 0, 0, 0, 0, "R12");
        target_mode = 1;
        step(0, 7, 0, 0, 0, 0, "R12");
        rx_full = 0;

        // R4: matched address stretch
        addr_byte = 1; addr_match = 1; ie_addr = 1;
        step(1, 8, 0, 0, 0, 1, "R4");
        step(0, 0, 0, 0, 1, 0, "R4");
        addr_match = 0;
        step(1, 8, 0, 0, 0, 0, "R4");
        addr_byte = 0; ie_addr = 0;

        // R5: write-data stretch
        ie_wdata = 1; rx_dir = 1;
        step(1, 8, 0, 0, 0, 1, "R5");
        step(0, 0, 0, 0, 1, 0, "R5");
        addr_byte = 1;
        step(1, 8, 0, 0, 0, 0, "R5");
        addr_byte = 0; ie_wdata = 0; rx_dir = 0;

        // R6: acknowledge-time stretch
        ie_ack = 1;
        step(1, 9, 0, 0, 0, 1, "R6");
        step(0, 0, 0, 0, 1, 0, "R6");
        step(1, 8, 0, 0, 0, 0, "R6");
        ie_ack = 0;

        // R7: 10-bit high address not yet read
        tenbit_lo = 1; addr_byte = 1; rx_full = 1;
        step(1, 8, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 1, 1, "R7");
        step(0, 0, 1, 0, 0, 1, "R7");
        rx_full = 0;
        step(0, 0, 0, 0, 1, 0, "R7");
        tenbit_lo = 0; addr_byte = 0;

        // R9: re-arm when buffer is full again; R11: read+clear together
        rx_full = 1;
        step(1, 7, 0, 0, 0, 1, "R9");
        step(0, 0, 1, 0, 0, 1, "R9");
        step(0, 0, 0, 0, 1, 1, "R9");
        step(0, 0, 0, 0, 1, 1, "R9");
        step(0, 0, 1, 0, 1, 0, "R11");
        rx_full = 0;

        // R11: set event beats a clear in the same cycle
        ie_ack = 1;
        step(1, 9, 0, 0, 1, 1, "R11");
        step(0, 0, 0, 0, 1, 0, "R11");

        // R10: disable drops the flag and blocks events
        step(1, 9, 0, 0, 0, 1, "R10");
        enable = 0;
        step(0, 0, 0, 0, 0, 0, "R10");
        step(1, 9, 0, 0, 0, 0, "R10");
        enable = 1;
        step(0, 0, 0, 0, 0, 0, "R10");
        ie_ack = 0;

        // R13: transmit-empty outranks address on edge 8
        tx_empty = 1; addr_byte = 1; addr_match = 1; ie_addr = 1;
        step(1, 8, 0, 0, 0, 1, "R13");
        step(0, 0, 0, 0, 1, 1, "R13");
        step(0, 0, 0, 1, 0, 1, "R13");
        tx_empty = 0;
        step(0, 0, 0, 0, 1, 0, "R13");
        addr_byte = 0; addr_match = 0; ie_addr = 0;

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule